// File: doc/BRIEF.md
# Shared Time Base and Watchdog Timer

This block derives a periodic time-base signal and a watchdog time-out flag from one ripple-style divider chain. The chain advances on a reference enable pulse that arrives at 32 kHz. When the reference runs at 256 kHz, a three-stage prescaler first divides it by eight. A three-bit rate field selects a tap on the chain, which gives a square wave of 1, 2, 4, 8, 16, 32, 64 or 128 Hz. A two-stage counter counts full periods of that tap, and the watchdog flag sets after four of them.

A command decoder upstream feeds the block one-cycle command pulses. These commands halt or run the shared chain, choose whether the square wave or the watchdog flag reaches the interrupt pin, clear the chain or the watchdog stages, change the rate, and enable or release the interrupt pin. The pin is open-drain, so the block drives it through two signals: an output enable and a pull-low level. While the system enable is low, the block is held stopped and its counters are emptied.

Top module: `timebase_wdt`

## Requirements
- R1: After reset, `irqOe` and `irqPullLow` are both 0. The rate field is 7, the chain is running, and neither source is routed to the pin.
- R2: With the prescaler bypassed, rate k puts out a square wave with a period of 2^(15-k) reference ticks. The wave is low for the first half-period after the chain clears. When the wave is routed and the pin is enabled, `irqPullLow` is 1 while the wave is low.
- R3: When `srcFast` is 1, the chain advances once per 8 reference ticks. When `srcFast` is 0, it advances on every reference tick.
- R4: The watchdog flag sets on the tick that completes the fourth full period of the selected tap after a watchdog clear.
- R5: Once set, the watchdog flag holds until a watchdog clear (opcode 6) or an interrupt release (opcode 7). With the flag routed and the pin enabled, `irqPullLow` follows the flag.
- R6: Halt (opcode 1) freezes the chain. Watchdog route (opcode 2) and wave route (opcode 4) both restart it from the value it held.
- R7: Opcode 2 routes the watchdog flag to the pin. Opcode 4 routes the square wave. Opcode 3 routes nothing, so the pin is enabled but not pulled low.
- R8: Opcode 5 clears the chain and the prescaler but keeps the count of completed watchdog periods.
- R9: Opcode 7 sets `irqOe` to 0 and clears the watchdog flag. Opcode 8 sets `irqOe` back to 1. While `irqOe` is 0, `irqPullLow` is 0.
- R10: While `sysEn` is 0, the pin is released and the chain, prescaler, period count and flag are held at zero. The routing, rate and pin-enable settings are kept.
- R11: A clear that arrives in the same cycle as a reference tick wins, and leaves the chain at zero.
- R12: A command is taken when `cmdValid` is 1. Its opcode is on `cmdOp`: 0 no-op, 1 halt, 2 watchdog route, 3 no route, 4 wave route, 5 chain clear, 6 watchdog clear, 7 interrupt release, 8 interrupt enable, 9 set rate from `cmdArg`. Its effect is visible after the clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sysEn | input | 1 | System enable; low stops and empties the block |
| refTick | input | 1 | One-cycle reference enable at 32 kHz or 256 kHz |
| srcFast | input | 1 | 1 when the reference is 256 kHz, which engages the divide-by-8 prescaler |
| cmdValid | input | 1 | Command strobe |
| cmdOp | input | 4 | Command opcode |
| cmdArg | input | 3 | Rate field for the set-rate command |
| irqOe | output | 1 | Interrupt pin drive enable |
| irqPullLow | output | 1 | Interrupt pin pulled low when 1 |

## Verification
The assertions take for granted that `cmdValid` is a clean one-cycle strobe. They also assume `srcFast` changes only while the chain is about to be cleared, so that no prescaler phase is left over from the other source. The stimulus changes `srcFast` only at a negative edge and issues a chain clear right after, and it sends one command per cycle. It holds `refTick` high on every cycle, which makes every clear coincide with a reference tick. The edge counts in each scenario are then exact.

// File: rtl/tbwdt_pkg.sv
package tbwdt_pkg;

  localparam int RATE_W = 3;

  typedef enum logic [3:0] {
    OP_NOP       = 4'd0,
    OP_HALT      = 4'd1,
    OP_WATCH_ON  = 4'd2,
    OP_ROUTE_OFF = 4'd3,
    OP_WAVE_ON   = 4'd4,
    OP_CLR_CHAIN = 4'd5,
    OP_CLR_WATCH = 4'd6,
    OP_IRQ_OFF   = 4'd7,
    OP_IRQ_ON    = 4'd8,
    OP_SET_RATE  = 4'd9
  } op_e;

  typedef enum logic [1:0] {
    ROUTE_NONE = 2'd0,
    ROUTE_WAVE = 2'd1,
    ROUTE_FLAG = 2'd2
  } route_e;

  // strobes and settings handed from control to datapath
  typedef struct packed {
    logic              clrChain;
    logic              clrWatch;
    logic              clrFlag;
    logic              runEn;
    logic [RATE_W-1:0] rateSel;
  } strobes_t;

endpackage

// File: rtl/tbwdt_datapath.sv
module tbwdt_datapath
  import tbwdt_pkg::*;
#(
  parameter int CHAIN_W = 15,
  parameter int PRE_W   = 3,
  parameter int WD_W    = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     sysEn,
  input  logic     refTick,
  input  logic     srcFast,
  input  strobes_t stb,
  output logic     tapWave,
  output logic     wdtFlag
);

  localparam logic [CHAIN_W-1:0] ALL_ONES = {CHAIN_W{1'b1}};

  logic [PRE_W-1:0]   preCnt;
  logic [CHAIN_W-1:0] chain;
  logic [WD_W-1:0]    periodCnt;
  logic               baseTick;
  logic [CHAIN_W-1:0] lowMask;
  logic [CHAIN_W-1:0] shifted;
  logic               periodEnd;

  // prescaler: one base tick per 2**PRE_W reference ticks in fast mode
  assign baseTick = srcFast ? (refTick && (preCnt == {PRE_W{1'b1}})) : refTick;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            preCnt <= '0;
    else if (!sysEn || stb.clrChain)      preCnt <= '0;
    else if (stb.runEn && srcFast && refTick) preCnt <= preCnt + 1'b1;
  end

  // shared divider chain
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        chain <= '0;
    else if (!sysEn || stb.clrChain)  chain <= '0;
    else if (stb.runEn && baseTick)   chain <= chain + 1'b1;
  end

  // selected tap and its period boundary
  assign shifted   = chain << stb.rateSel;
  assign tapWave   = shifted[CHAIN_W-1];
  assign lowMask   = ALL_ONES >> stb.rateSel;
  assign periodEnd = stb.runEn && baseTick && ((chain & lowMask) == lowMask);

  // watchdog extension stages and sticky time-out flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      periodCnt <= '0;
      wdtFlag   <= 1'b0;
    end else if (!sysEn || stb.clrWatch) begin
      periodCnt <= '0;
      wdtFlag   <= 1'b0;
    end else begin
      if (periodEnd && !stb.clrChain) begin
        periodCnt <= periodCnt + 1'b1;
        if (periodCnt == {WD_W{1'b1}}) wdtFlag <= 1'b1;
      end
      if (stb.clrFlag) wdtFlag <= 1'b0;
    end
  end

  assert_flag_holds_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wdtFlag && sysEn && !stb.clrWatch && !stb.clrFlag) |=> wdtFlag);

  assert_halt_freezes_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.runEn && !stb.clrChain && sysEn) |=> $stable(chain));

  assert_sys_off_empties_R10: assert property (@(posedge clk) disable iff (!rstN)
    !sysEn |=> (chain == '0 && preCnt == '0 && periodCnt == '0 && !wdtFlag));

  assert_clear_wins_R11: assert property (@(posedge clk) disable iff (!rstN)
    (stb.clrChain && sysEn && refTick) |=> (chain == '0));

  assert_bypass_steps_R3: assert property (@(posedge clk) disable iff (!rstN)
    (sysEn && !srcFast && refTick && stb.runEn && !stb.clrChain)
      |=> (chain == CHAIN_W'($past(chain) + 1'b1)));

endmodule

// File: rtl/tbwdt_ctrl.sv
module tbwdt_ctrl
  import tbwdt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              sysEn,
  input  logic              cmdValid,
  input  logic [3:0]        cmdOp,
  input  logic [RATE_W-1:0] cmdArg,
  input  logic              tapWave,
  input  logic              wdtFlag,
  output strobes_t          stb,
  output logic              irqOe,
  output logic              irqPullLow
);

  op_e               op;
  logic              runEn;
  route_e            route;
  logic              irqEn;
  logic [RATE_W-1:0] rateSel;
  logic              srcLow;

  assign op = op_e'(cmdOp);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runEn   <= 1'b1;
      route   <= ROUTE_NONE;
      irqEn   <= 1'b0;
      rateSel <= {RATE_W{1'b1}};
    end else if (cmdValid) begin
      unique case (op)
        OP_HALT:      runEn <= 1'b0;
        OP_WATCH_ON:  begin runEn <= 1'b1; route <= ROUTE_FLAG; end
        OP_WAVE_ON:   begin runEn <= 1'b1; route <= ROUTE_WAVE; end
        OP_ROUTE_OFF: route <= ROUTE_NONE;
        OP_IRQ_OFF:   irqEn <= 1'b0;
        OP_IRQ_ON:    irqEn <= 1'b1;
        OP_SET_RATE:  rateSel <= cmdArg;
        default:      ;
      endcase
    end
  end

  always_comb begin
    stb.clrChain = cmdValid && (op == OP_CLR_CHAIN || op == OP_CLR_WATCH);
    stb.clrWatch = cmdValid && (op == OP_CLR_WATCH);
    stb.clrFlag  = cmdValid && (op == OP_IRQ_OFF);
    stb.runEn    = runEn;
    stb.rateSel  = rateSel;
  end

  always_comb begin
    unique case (route)
      ROUTE_WAVE: srcLow = !tapWave;
      ROUTE_FLAG: srcLow = wdtFlag;
      default:    srcLow = 1'b0;
    endcase
  end

  assign irqOe      = irqEn && sysEn;
  assign irqPullLow = irqOe && srcLow;

  assert_released_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    !irqOe |-> !irqPullLow);

  assert_release_cmd_R9: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && op == OP_IRQ_OFF) |=> !irqOe);

  assert_enable_cmd_R12: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && op == OP_IRQ_ON && sysEn) |=> (irqOe || !sysEn));

endmodule

// File: rtl/timebase_wdt.sv
module timebase_wdt
  import tbwdt_pkg::*;
#(
  parameter int CHAIN_W = 15,
  parameter int PRE_W   = 3,
  parameter int WD_W    = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sysEn,
  input  logic              refTick,
  input  logic              srcFast,
  input  logic              cmdValid,
  input  logic [3:0]        cmdOp,
  input  logic [RATE_W-1:0] cmdArg,
  output logic              irqOe,
  output logic              irqPullLow
);

  strobes_t stb;
  logic     tapWave;
  logic     wdtFlag;

  tbwdt_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .sysEn      (sysEn),
    .cmdValid   (cmdValid),
    .cmdOp      (cmdOp),
    .cmdArg     (cmdArg),
    .tapWave    (tapWave),
    .wdtFlag    (wdtFlag),
    .stb        (stb),
    .irqOe      (irqOe),
    .irqPullLow (irqPullLow)
  );

  tbwdt_datapath #(
    .CHAIN_W (CHAIN_W),
    .PRE_W   (PRE_W),
    .WD_W    (WD_W)
  ) i_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .sysEn   (sysEn),
    .refTick (refTick),
    .srcFast (srcFast),
    .stb     (stb),
    .tapWave (tapWave),
    .wdtFlag (wdtFlag)
  );

endmodule

// File: tb/test_timebase_wdt.sv
`timescale 1ns/1ps
module test_timebase_wdt;

  logic       clk = 1'b0;
  logic       rstN;
  logic       sysEn;
  logic       refTick;
  logic       srcFast;
  logic       cmdValid;
  logic [3:0] cmdOp;
  logic [2:0] cmdArg;
  logic       irqOe;
  logic       irqPullLow;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  timebase_wdt i_timebase_wdt (
    .clk        (clk),
    .rstN       (rstN),
    .sysEn      (sysEn),
    .refTick    (refTick),
    .srcFast    (srcFast),
    .cmdValid   (cmdValid),
    .cmdOp      (cmdOp),
    .cmdArg     (cmdArg),
    .irqOe      (irqOe),
    .irqPullLow (irqPullLow)
  );

  task automatic chk(input string tag, input logic [1:0] exp);
    total++;
    if ({irqOe, irqPullLow} !== exp) begin
      bad++;
      $display("FAIL %s: {oe,low} actual=%b expected=%b at %0t", tag, {irqOe, irqPullLow}, exp, $time);
    end
  endtask

  task automatic send(input logic [3:0] op, input logic [2:0] arg = 3'd0);
    cmdValid = 1'b1;
    cmdOp    = op;
    cmdArg   = arg;
    @(negedge clk);
    cmdValid = 1'b0;
    cmdOp    = 4'd0;
    cmdArg   = 3'd0;
  endtask

  task automatic waitEdges(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic testReset();
    chk("R1 reset released", 2'b00);
  endtask

  task automatic testWave128();
    send(4'd8);
    send(4'd4);
    send(4'd5);
    chk("R7 wave routed low after clear R11", 2'b11);
    waitEdges(127);
    chk("R2 half period not yet", 2'b11);
    waitEdges(1);
    chk("R2 wave high at 128", 2'b10);
    waitEdges(128);
    chk("R2 wave low again at 256", 2'b11);
  endtask

  task automatic testRates();
    send(4'd9, 3'd4);
    send(4'd5);
    waitEdges(1023);
    chk("R2 rate4 before half", 2'b11);
    waitEdges(1);
    chk("R2 rate4 half period", 2'b10);
    send(4'd9, 3'd0);
    send(4'd5);
    waitEdges(16383);
    chk("R2 rate0 before half", 2'b11);
    waitEdges(1);
    chk("R2 rate0 half period", 2'b10);
    send(4'd9, 3'd7);
  endtask

  task automatic testHalt();
    send(4'd5);
    waitEdges(100);
    send(4'd1);
    waitEdges(300);
    chk("R6 halted chain frozen", 2'b11);
    send(4'd4);
    waitEdges(26);
    chk("R6 resumed not yet high", 2'b11);
    waitEdges(1);
    chk("R6 resumed from held value", 2'b10);
  endtask

  task automatic testPrescale();
    srcFast = 1'b1;
    send(4'd5);
    waitEdges(1023);
    chk("R3 prescaled before half", 2'b11);
    waitEdges(1);
    chk("R3 prescaled half period", 2'b10);
    srcFast = 1'b0;
    send(4'd5);
    waitEdges(128);
    chk("R3 bypass again", 2'b10);
  endtask

  task automatic testWatchdog();
    send(4'd2);
    send(4'd6);
    chk("R7 flag routed, clear", 2'b10);
    waitEdges(1023);
    chk("R4 no timeout yet", 2'b10);
    waitEdges(1);
    chk("R4 timeout after four periods", 2'b11);
    waitEdges(2000);
    chk("R5 flag sticky", 2'b11);
    send(4'd6);
    chk("R5 watchdog clear drops flag", 2'b10);
  endtask

  task automatic testClearChainOnly();
    send(4'd6);
    waitEdges(599);
    send(4'd5);
    waitEdges(511);
    chk("R8 period count kept, not yet", 2'b10);
    waitEdges(1);
    chk("R8 timeout two periods after chain clear", 2'b11);
  endtask

  task automatic testIrqOff();
    send(4'd7);
    chk("R9 release", 2'b00);
    send(4'd8);
    chk("R9 re-enable, flag cleared", 2'b10);
    send(4'd3);
    waitEdges(5);
    chk("R7 no route not pulled", 2'b10);
  endtask

  task automatic testSysOff();
    send(4'd4);
    send(4'd5);
    waitEdges(200);
    sysEn = 1'b0;
    waitEdges(5);
    chk("R10 system off releases pin", 2'b00);
    sysEn = 1'b1;
    waitEdges(127);
    chk("R10 restart from zero, config kept", 2'b11);
    waitEdges(1);
    chk("R10 half period after restart", 2'b10);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog R1: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rstN     = 1'b0;
    sysEn    = 1'b1;
    refTick  = 1'b1;
    srcFast  = 1'b0;
    cmdValid = 1'b0;
    cmdOp    = 4'd0;
    cmdArg   = 3'd0;
    waitEdges(3);
    rstN = 1'b1;
    waitEdges(1);
    testReset();
    testWave128();
    testRates();
    testHalt();
    testPrescale();
    testWatchdog();
    testClearChainOnly();
    testIrqOff();
    testSysOff();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule